// File: doc/BRIEF.md
# USB Core Global Register Bank with Selective Soft Reset

This block is the global control and status register bank of a USB controller core. Software reaches it through a plain word-wide request bus: one valid strobe, a write flag, a byte offset inside the bank and 32 bits of write data. Reads come back through a registered data port one cycle after the request. The bank holds the core control word, a status word with sticky event flags, a fixed core identity, a user identity that always reverts to a strap value, two user-control words, the bus and frame-timing configuration, and nine hardware-parameter words fixed at elaboration.

Writable registers carry a per-bit protection mask. Protected bits keep their value whatever is written. The status word has two sticky flags that hardware sets and software clears by writing ones. When software writes the control word with the core soft-reset bit (bit 11) set, the bank puts its configuration registers back to their defaults and leaves the control, status, identity and user-control words untouched. On the same write it raises a one-cycle pulse, so a neighbouring host-controller register block can reset in step. The synchronous hard reset restores every writable register. The hardware-parameter and identity words are constants that neither reset touches.

Top module: `csrb_top`

## Requirements
- R1: A read request (req_valid=1, req_write=0) gives rd_valid=1 and rd_data one clock edge later. In every other cycle rd_valid=0 and rd_data=0.
- R2: After hard reset these offsets read the following values: 0x04 → 0x00000300, 0x10 → 0x30C13004, 0x18 → 0x7E800000, 0x1C → 0x0000198A, 0x2C → 0x0C808010, 0x530 → 0x0C83F020.
- R3: A write to a writable register changes only the bits outside its protection mask. The masks are 0x04: 0xFFFFE0FF, 0x1C: 0x00007800, 0x2C: 0x001C8000, 0x530: 0x00400040. The control word 0x10 has no protected bits.
- R4: Offset 0x20 always reads 0x5533330A, and writes to it have no effect.
- R5: Offsets 0x40..0x5C read 0x40204048|MODE, 0x0222493B, 0x12345678, 0x0618C088, 0x47822004, 0x04202088, 0x07850C20, 0x00000000. Offset 0x500 reads 0x00000478. All of them ignore writes. MODE defaults to 1 (host).
- R6: In status word 0x18, bit 4 is set by evt_set[0] and bit 5 by evt_set[1]. Software clears them by writing 1 to them. A set in the same cycle as a clear wins. All other bits are read-only.
- R7: Offset 0x28 resets to UID_STRAP (default 0x12345678). A written value is held for exactly one cycle, and then the register returns to UID_STRAP.
- R8: A write to 0x10 with bit 11 set restores 0x04, 0x1C and 0x530 to their R2 values. It keeps 0x10, 0x18, 0x28 and 0x2C as they were.
- R9: Bit 11 of 0x10 does not clear itself. It reads back as written, and every write with bit 11 set applies the R8 restore again.
- R10: soft_reset_pulse is high for exactly the one cycle after each write that triggers R8, and low at all other times.
- R11: Offsets that are unmapped or not word-aligned read 0. Writes to them change no register.
- R12: Hard reset returns every writable register, including 0x10, 0x18 and 0x2C, to its R2 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the bank |
| req_wdata | input | 32 | Write data |
| evt_set | input | 2 | Hardware set strobes for status bits 5:4 |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Registered read data |
| soft_reset_pulse | output | 1 | One-cycle pulse after a soft-reset write |

## Verification
Every output is due exactly one clock edge after the request or event that causes it. A write or set becomes visible to a read issued in the next cycle. The user identity can be seen only by a read issued in the cycle right after the write. The bench drives each cycle's inputs on the falling edge and steps its reference model once per rising edge. It compares rd_valid, rd_data and soft_reset_pulse just after that edge, so each result is checked in the cycle it is due and never a cycle late.

// File: rtl/csrb_pkg.sv
package csrb_pkg;

  localparam int DW       = 32;
  localparam int NREG     = 17;
  localparam int CTRL_IDX = 1;
  localparam int STAT_IDX = 2;

  typedef enum logic [1:0] {
    K_RW    = 2'd0,
    K_CONST = 2'd1,
    K_SNAP  = 2'd2
  } kind_e;

  typedef struct packed {
    logic [15:0]   off;
    kind_e         kind;
    logic          keep;   // survives the soft reset
    logic [DW-1:0] rst;
    logic [DW-1:0] ro;
    logic [DW-1:0] w1c;
  } desc_t;

  function automatic desc_t mk(input logic [15:0] off, input kind_e k,
                               input logic keep, input logic [DW-1:0] rst,
                               input logic [DW-1:0] ro, input logic [DW-1:0] w1c);
    desc_t d;
    d.off  = off;
    d.kind = k;
    d.keep = keep;
    d.rst  = rst;
    d.ro   = ro;
    d.w1c  = w1c;
    return d;
  endfunction

  function automatic logic [DW-1:0] hwp(input int k, input logic [1:0] mode);
    case (k)
      0:       return 32'h4020_4048 | {30'd0, mode};
      1:       return 32'h0222_493B;
      2:       return 32'h1234_5678;
      3:       return 32'h0618_C088;
      4:       return 32'h4782_2004;
      5:       return 32'h0420_2088;
      6:       return 32'h0785_0C20;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic desc_t reg_desc(input int i, input logic [DW-1:0] uid,
                                     input logic [1:0] mode);
    case (i)
      0:  return mk(16'h004, K_RW,    1'b0, 32'h0000_0300, 32'hFFFF_E0FF, 32'h0);
      1:  return mk(16'h010, K_RW,    1'b1, 32'h30C1_3004, 32'h0,         32'h0);
      2:  return mk(16'h018, K_RW,    1'b1, 32'h7E80_0000, 32'hFFFF_FFCF, 32'h30);
      3:  return mk(16'h01C, K_RW,    1'b0, 32'h0000_198A, 32'h0000_7800, 32'h0);
      4:  return mk(16'h020, K_CONST, 1'b1, 32'h5533_330A, 32'hFFFF_FFFF, 32'h0);
      5:  return mk(16'h028, K_SNAP,  1'b1, uid,           32'h0,         32'h0);
      6:  return mk(16'h02C, K_RW,    1'b1, 32'h0C80_8010, 32'h001C_8000, 32'h0);
      15: return mk(16'h500, K_CONST, 1'b1, 32'h0000_0478, 32'hFFFF_FFFF, 32'h0);
      16: return mk(16'h530, K_RW,    1'b0, 32'h0C83_F020, 32'h0040_0040, 32'h0);
      default: return mk(16'h040 + 16'(4 * (i - 7)), K_CONST, 1'b1,
                         hwp(i - 7, mode), 32'hFFFF_FFFF, 32'h0);
    endcase
  endfunction

endpackage

// File: rtl/csrb_dec.sv
module csrb_dec #(
  parameter int          ADDR_W    = 11,
  parameter logic [31:0] UID_STRAP = 32'h1234_5678,
  parameter logic [1:0]  MODE      = 2'd1
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic [csrb_pkg::NREG-1:0] hit
);
  import csrb_pkg::*;

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    localparam desc_t D = reg_desc(i, UID_STRAP, MODE);
    assign hit[i] = ({{(16 - ADDR_W){1'b0}}, addr} == D.off);
  end
endmodule

// File: rtl/csrb_cell.sv
module csrb_cell #(
  parameter int          DW   = 32,
  parameter logic [31:0] RST  = '0,
  parameter logic [31:0] RO   = '0,
  parameter logic [31:0] W1C  = '0,
  parameter bit          KEEP = 1'b0,
  parameter bit          SNAP = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_clr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] set_bits,
  output logic [DW-1:0] q
);
  logic [DW-1:0] wr_val;

  always_comb begin
    wr_val = (q & RO) | (wdata & ~RO & ~W1C) | (q & W1C & ~wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST;
    end else if (soft_clr && !KEEP) begin
      q <= RST;
    end else if (we) begin
      q <= wr_val | set_bits;
    end else if (SNAP) begin
      q <= RST;
    end else begin
      q <= q | set_bits;
    end
  end
endmodule

// File: rtl/csrb_top.sv
module csrb_top #(
  parameter int          ADDR_W    = 11,
  parameter logic [31:0] UID_STRAP = 32'h1234_5678,
  parameter logic [1:0]  MODE      = 2'd1,
  parameter int          SRST_BIT  = 11,
  parameter int          EVT_LSB   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        evt_set,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              soft_reset_pulse
);
  import csrb_pkg::*;

  logic [NREG-1:0] hit;
  logic [DW-1:0]   q [NREG];
  logic            wr_fire;
  logic            rd_fire;
  logic            soft_clr;
  logic [DW-1:0]   rmux;

  assign wr_fire  = req_valid && req_write;
  assign rd_fire  = req_valid && !req_write;
  assign soft_clr = wr_fire && hit[CTRL_IDX] && req_wdata[SRST_BIT];

  csrb_dec #(.ADDR_W(ADDR_W), .UID_STRAP(UID_STRAP), .MODE(MODE)) u_dec (
    .addr (req_addr),
    .hit  (hit)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam desc_t D = reg_desc(i, UID_STRAP, MODE);
    if (D.kind == K_CONST) begin : g_const
      assign q[i] = D.rst;
    end else begin : g_cell
      logic [DW-1:0] setb;
      if (i == STAT_IDX) begin : g_evt
        assign setb = DW'(evt_set) << EVT_LSB;
      end else begin : g_noevt
        assign setb = '0;
      end
      csrb_cell #(
        .DW   (DW),
        .RST  (D.rst),
        .RO   (D.ro),
        .W1C  (D.w1c),
        .KEEP (D.keep),
        .SNAP (D.kind == K_SNAP)
      ) u_cell (
        .clk      (clk),
        .rst      (rst),
        .soft_clr (soft_clr),
        .we       (wr_fire && hit[i]),
        .wdata    (req_wdata),
        .set_bits (setb),
        .q        (q[i])
      );
    end
  end

  always_comb begin
    rmux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rmux = rmux | q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid         <= 1'b0;
      rd_data          <= '0;
      soft_reset_pulse <= 1'b0;
    end else begin
      rd_valid         <= rd_fire;
      rd_data          <= rd_fire ? rmux : '0;
      soft_reset_pulse <= soft_clr;
    end
  end
endmodule

// File: rtl/csrb_chk.sv
module csrb_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              soft_reset_pulse
);
  logic rd_req;
  logic srst_wr;
  assign rd_req  = req_valid && !req_write;
  assign srst_wr = req_valid && req_write && (req_addr == ADDR_W'(16'h010)) && req_wdata[11];

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (!rd_valid && rd_data == 32'h0));
  a_r4_core_id: assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_addr == ADDR_W'(16'h020)) |=> rd_data == 32'h5533_330A);
  a_r5_hwp8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_addr == ADDR_W'(16'h500)) |=> rd_data == 32'h0000_0478);
  a_r11_misaligned: assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_addr[1:0] != 2'b00) |=> rd_data == 32'h0);
  a_r10_pulse_fires: assert property (@(posedge clk) disable iff (rst)
    srst_wr |=> soft_reset_pulse);
  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    !srst_wr |=> !soft_reset_pulse);
endmodule

bind csrb_top csrb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .req_valid        (req_valid),
  .req_write        (req_write),
  .req_addr         (req_addr),
  .req_wdata        (req_wdata),
  .rd_valid         (rd_valid),
  .rd_data          (rd_data),
  .soft_reset_pulse (soft_reset_pulse)
);

// File: tb/csrb_top_tb.sv
module csrb_top_tb;
  localparam int          ADDR_W = 11;
  localparam logic [31:0] STRAP  = 32'h1234_5678;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr  = '0;
  logic [31:0]       req_wdata = '0;
  logic [1:0]        evt_set   = '0;
  logic              rd_valid;
  logic [31:0]       rd_data;
  logic              soft_reset_pulse;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  csrb_top #(.ADDR_W(ADDR_W), .UID_STRAP(STRAP), .MODE(2'd1)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .evt_set(evt_set),
    .rd_valid(rd_valid), .rd_data(rd_data), .soft_reset_pulse(soft_reset_pulse)
  );

  // reference model
  logic [31:0] m_val  [int];
  logic [31:0] m_rst  [int];
  logic [31:0] m_ro   [int];
  logic [31:0] m_w1c  [int];
  bit          m_keep [int];
  bit          m_cst  [int];

  task automatic add(int off, logic [31:0] r, logic [31:0] ro, logic [31:0] w1c, bit keep, bit cst);
    m_rst[off] = r; m_ro[off] = ro; m_w1c[off] = w1c; m_keep[off] = keep; m_cst[off] = cst;
  endtask

  task automatic model_init();
    logic [31:0] hw [8] = '{32'h4020_4049, 32'h0222_493B, 32'h1234_5678, 32'h0618_C088,
                            32'h4782_2004, 32'h0420_2088, 32'h0785_0C20, 32'h0};
    add('h004, 32'h0000_0300, 32'hFFFF_E0FF, 0, 0, 0);
    add('h010, 32'h30C1_3004, 0, 0, 1, 0);
    add('h018, 32'h7E80_0000, 32'hFFFF_FFCF, 32'h30, 1, 0);
    add('h01C, 32'h0000_198A, 32'h0000_7800, 0, 0, 0);
    add('h020, 32'h5533_330A, 32'hFFFF_FFFF, 0, 1, 1);
    add('h028, STRAP, 0, 0, 1, 0);
    add('h02C, 32'h0C80_8010, 32'h001C_8000, 0, 1, 0);
    for (int k = 0; k < 8; k++) add('h040 + 4 * k, hw[k], 32'hFFFF_FFFF, 0, 1, 1);
    add('h500, 32'h0000_0478, 32'hFFFF_FFFF, 0, 1, 1);
    add('h530, 32'h0C83_F020, 32'h0040_0040, 0, 0, 0);
  endtask

  task automatic model_hard();
    foreach (m_rst[a]) m_val[a] = m_rst[a];
  endtask

  function automatic logic [31:0] model_read(int a);
    if (m_val.exists(a)) return m_val[a];
    return 32'h0;
  endfunction

  // one clock: drive, step model, compare after the edge
  task automatic cycle(bit v, bit w, int a, logic [31:0] d, logic [1:0] ev, string tag);
    logic        e_rv, e_p;
    logic [31:0] e_rd;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = ADDR_W'(a); req_wdata = d; evt_set = ev;
    e_rv = 0; e_rd = 0; e_p = 0;
    if (rst) begin
      model_hard();
    end else begin
      if (v && !w) begin e_rv = 1; e_rd = model_read(a); end
      if (v && w && m_val.exists(a) && !m_cst[a]) begin
        logic [31:0] o;
        o = m_val[a];
        m_val[a] = (o & m_ro[a]) | (d & ~m_ro[a] & ~m_w1c[a]) | (o & m_w1c[a] & ~d);
      end
      if (!(v && w && a == 'h028)) m_val['h028] = STRAP;
      m_val['h018] = m_val['h018] | (32'(ev) << 4);
      if (v && w && a == 'h010 && d[11]) begin
        e_p = 1;
        foreach (m_keep[k]) if (!m_keep[k]) m_val[k] = m_rst[k];
      end
    end
    @(posedge clk);
    #1;
    n_cmp++;
    if (rd_valid !== e_rv || rd_data !== e_rd || soft_reset_pulse !== e_p) begin
      n_fail++;
      $display("FAIL %s: addr=%h got v=%b d=%h p=%b exp v=%b d=%h p=%b",
               tag, a, rd_valid, rd_data, soft_reset_pulse, e_rv, e_rd, e_p);
    end
  endtask

  task automatic rd(int a, string tag);  cycle(1, 0, a, 0, 0, tag); endtask
  task automatic wr(int a, logic [31:0] d, string tag); cycle(1, 1, a, d, 0, tag); endtask
  task automatic idle(string tag); cycle(0, 0, 0, 0, 0, tag); endtask

  task automatic read_all(string tag);
    foreach (m_rst[a]) rd(a, tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hung exp done");
      summary();
    end
  end

  initial begin
    model_init();
    model_hard();
    rst = 1;
    idle("R2"); idle("R2");
    @(negedge clk); rst = 0;
    // R2 R4 R5 R7: reset state of every register
    read_all("R2");
    idle("R1");
    // R11: unmapped and misaligned
    rd('h008, "R11"); rd('h600, "R11"); rd('h011, "R11"); rd('h502, "R11");
    wr('h008, 32'hFFFF_FFFF, "R11"); rd('h008, "R11");
    wr('h005, 32'hFFFF_FFFF, "R11"); rd('h004, "R11");
    // R3: protection masks
    wr('h004, 32'hFFFF_FFFF, "R3"); rd('h004, "R3");
    wr('h530, 32'h0000_0000, "R3"); rd('h530, "R3");
    wr('h01C, 32'hFFFF_FFFF, "R3"); rd('h01C, "R3");
    wr('h02C, 32'h0000_0000, "R3"); rd('h02C, "R3");
    wr('h010, 32'h0000_0000, "R3"); rd('h010, "R3");
    // R4 R5: constants ignore writes
    wr('h020, 32'h0, "R4"); rd('h020, "R4");
    wr('h040, 32'h0, "R5"); rd('h040, "R5");
    wr('h500, 32'h0, "R5"); rd('h500, "R5");
    // R6: status set / clear
    cycle(0, 0, 0, 0, 2'b01, "R6"); rd('h018, "R6");
    cycle(0, 0, 0, 0, 2'b10, "R6"); rd('h018, "R6");
    wr('h018, 32'hFFFF_FFDF, "R6"); rd('h018, "R6");
    cycle(1, 1, 'h018, 32'h30, 2'b01, "R6"); rd('h018, "R6");
    wr('h018, 32'h30, "R6"); rd('h018, "R6");
    // R7: user id snaps back
    wr('h028, 32'hDEAD_BEEF, "R7"); rd('h028, "R7"); rd('h028, "R7");
    wr('h028, 32'hCAFE_0001, "R7"); idle("R7"); rd('h028, "R7");
    // R8 R9 R10: selective soft reset
    wr('h004, 32'h0000_1500, "R8"); wr('h01C, 32'h0, "R8"); wr('h530, 32'h0, "R8");
    wr('h02C, 32'h0000_0000, "R8");
    cycle(0, 0, 0, 0, 2'b01, "R8");
    wr('h010, 32'h0000_0800, "R10"); idle("R10");
    rd('h004, "R8"); rd('h01C, "R8"); rd('h530, "R8");
    rd('h02C, "R8"); rd('h018, "R8"); rd('h028, "R8");
    rd('h010, "R9");
    wr('h004, 32'h0000_0A00, "R9"); rd('h004, "R9");
    wr('h010, 32'h0000_0801, "R9"); rd('h004, "R9"); rd('h010, "R9");
    wr('h010, 32'h0000_0000, "R10"); idle("R10");
    wr('h010, 32'h0000_0800, "R10"); wr('h010, 32'h0000_0800, "R10"); idle("R10");
    // R12: hard reset restores all writable registers
    wr('h010, 32'h1234_0000, "R12"); wr('h02C, 32'h0, "R12"); wr('h004, 32'h0, "R12");
    cycle(0, 0, 0, 0, 2'b11, "R12");
    @(negedge clk); rst = 1;
    idle("R12"); idle("R12");
    @(negedge clk); rst = 0;
    read_all("R12");
    idle("R1");
    done = 1;
    summary();
  end
endmodule